// File: doc/BRIEF.md
# Flash Command Interface Controller

This block is the command front end of an emulated NOR flash device with an 8-bit host bus. A host writes command bytes through a synchronous write strobe. The block decides from those bytes what later reads return: stored array bytes, identifier codes, a short query signature, or the status register. It also runs two-write sequences for single-byte program, block erase, lock management and configuration. The storage is a small register array organised in equal blocks, so the whole device fits in simulation.

Program and erase are instantaneous. A program can only clear bits. An erase returns a whole block to all ones. Each block has its own lock bit, and a master lock protects the block lock bits themselves. A hard-unlock input overrides every lock. Error bits in the status register accumulate until the host issues the clear-status command. Locks refused on program and on erase leave different marks in the status register.

Top module: `flash_cmd_ctrl`

## Requirements
- R1: After reset every array byte reads 0xFF, the read mode is array read, the status register is 0x80, no block or master lock is set, and `rd_data` is 0x00.
- R2: In any of the four read modes a write of 0xFF selects array read, 0x90 selects identifier read, 0x98 selects query read and 0x70 selects status read.
- R3: Status bits 5, 4, 3 and 1 are error flags. Once set, an error flag stays set until a write of 0x50 in a read mode, which selects status read and ANDs the status with 0xC5.
- R4: A write of 0x40 or 0x10 in a read mode arms a program. The next write ANDs its data into the addressed byte, and the mode then becomes status read.
- R5: A write of 0x20 in a read mode arms an erase. A following write of 0xD0 sets every byte of the block that holds the write address to 0xFF and selects status read. Any other byte leaves the erase armed, and reads in that state return array data.
- R6: If hard unlock is low, a program aimed at a locked block ORs 0x12 into the status and an erase of a locked block ORs 0x22, and the array is left unchanged. With hard unlock high, both operations proceed.
- R7: In identifier mode, byte addresses 0 and 1 return 0x89 and addresses 2 and 3 return 0x15. Addresses 6 and 7 return the master lock in bit 0. Elsewhere, byte offsets 4 and 5 within a block return that block's lock bit in bit 0. All other addresses return 0x00.
- R8: In query mode, byte addresses 0x20/0x21 return 0x51, 0x22/0x23 return 0x52 and 0x24/0x25 return 0x59. Addresses 0 to 3 return the identifier codes of R7, and all other addresses return 0x00.
- R9: A write of 0x60 in a read mode arms a lock sequence, and the next write ends it in status read:
  - 0x01 sets the addressed block's lock and 0xD0 clears it, unless the master lock is set with hard unlock low; the status then gains 0x12 or 0x22 respectively.
  - 0xF1 sets the master lock only with hard unlock high, and otherwise ORs 0x12 into the status.
  - 0x03 changes nothing, and any other byte ORs 0x30 into the status.
- R10: In a read mode, the bytes 0xB0 and 0xD0 and every undefined byte change nothing. A write of 0xB8 arms configuration; the next write is consumed without touching the array and the mode becomes status read.
- R11: `rd_data` is registered. It takes the value selected by the mode and address one clock after a cycle with `rd_en` high, and it holds its value in every cycle without `rd_en`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| addr | input | ADDR_W | Byte address for reads and writes |
| wr_data | input | 8 | Command or data byte |
| wr_en | input | 1 | Write strobe, one byte per cycle |
| rd_en | input | 1 | Read strobe |
| hard_unlock | input | 1 | Overrides all lock checks while high |
| rd_data | output | 8 | Registered read data |

## Verification
The assertions assume that reads and writes never share a cycle and that each strobe is high for a single clock per access. They also assume `addr`, `wr_data` and `hard_unlock` are steady across the clock edge that samples them. The stimulus drives all inputs on the falling edge. Each access task raises exactly one strobe for one cycle and returns it low. `hard_unlock` changes only between complete command sequences, never between the two writes of a sequence.

// File: rtl/fci_pkg.sv
package fci_pkg;

    typedef enum logic [2:0] {
        MODE_ARRAY  = 3'd0,
        MODE_IDENT  = 3'd1,
        MODE_QUERY  = 3'd2,
        MODE_STATUS = 3'd3,
        MODE_PROG   = 3'd4,
        MODE_ERASE  = 3'd5,
        MODE_LOCK   = 3'd6,
        MODE_CONF   = 3'd7
    } fci_mode_e;

    typedef struct packed {
        logic prog;
        logic erase;
        logic lock_set;
        logic lock_clr;
        logic master_set;
    } fci_op_t;

    localparam logic [7:0] CMD_ARRAY      = 8'hFF;
    localparam logic [7:0] CMD_IDENT      = 8'h90;
    localparam logic [7:0] CMD_QUERY      = 8'h98;
    localparam logic [7:0] CMD_STATUS     = 8'h70;
    localparam logic [7:0] CMD_CLR_STATUS = 8'h50;
    localparam logic [7:0] CMD_PROG_A     = 8'h40;
    localparam logic [7:0] CMD_PROG_B     = 8'h10;
    localparam logic [7:0] CMD_ERASE      = 8'h20;
    localparam logic [7:0] CMD_CONFIRM    = 8'hD0;
    localparam logic [7:0] CMD_CONFIG     = 8'hB8;
    localparam logic [7:0] CMD_LOCK       = 8'h60;
    localparam logic [7:0] SUB_BLK_LOCK   = 8'h01;
    localparam logic [7:0] SUB_MASTER     = 8'hF1;
    localparam logic [7:0] SUB_READ_CFG   = 8'h03;

    localparam logic [7:0] STATUS_RESET   = 8'h80;
    localparam logic [7:0] STATUS_KEEP    = 8'hC5;
    localparam logic [7:0] ERR_LOCK_PROG  = 8'h12;
    localparam logic [7:0] ERR_LOCK_ERASE = 8'h22;
    localparam logic [7:0] ERR_SEQUENCE   = 8'h30;
    localparam logic [7:0] ERR_FLAGS      = 8'h3A;

    localparam logic [7:0] CODE_MAKER     = 8'h89;
    localparam logic [7:0] CODE_DEVICE    = 8'h15;

    function automatic logic is_read_mode(fci_mode_e m);
        return (m == MODE_ARRAY) || (m == MODE_IDENT) ||
               (m == MODE_QUERY) || (m == MODE_STATUS);
    endfunction

    function automatic logic [7:0] query_sig(logic [15:0] word);
        case (word)
            16'h0010: return 8'h51;
            16'h0011: return 8'h52;
            16'h0012: return 8'h59;
            default:  return 8'h00;
        endcase
    endfunction

endpackage

// File: rtl/fci_cmd_fsm.sv
module fci_cmd_fsm
    import fci_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       wr_en,
    input  logic [7:0] wr_data,
    input  logic       blk_locked,
    input  logic       master_lock,
    input  logic       hard_unlock,
    output fci_mode_e  mode,
    output logic [7:0] status,
    output fci_op_t    op
);

    fci_mode_e  mode_q, mode_d;
    logic [7:0] status_q, status_d;
    logic       guarded;
    logic       master_guard;

    assign guarded      = blk_locked && !hard_unlock;
    assign master_guard = master_lock && !hard_unlock;

    always_comb begin
        mode_d   = mode_q;
        status_d = status_q;
        op       = '0;
        if (wr_en) begin
            unique case (mode_q)
                MODE_ARRAY, MODE_IDENT, MODE_QUERY, MODE_STATUS: begin
                    case (wr_data)
                        CMD_ARRAY:  mode_d = MODE_ARRAY;
                        CMD_IDENT:  mode_d = MODE_IDENT;
                        CMD_QUERY:  mode_d = MODE_QUERY;
                        CMD_STATUS: mode_d = MODE_STATUS;
                        CMD_CLR_STATUS: begin
                            mode_d   = MODE_STATUS;
                            status_d = status_q & STATUS_KEEP;
                        end
                        CMD_PROG_A, CMD_PROG_B: mode_d = MODE_PROG;
                        CMD_ERASE:  mode_d = MODE_ERASE;
                        CMD_CONFIG: mode_d = MODE_CONF;
                        CMD_LOCK:   mode_d = MODE_LOCK;
                        default:    mode_d = mode_q;
                    endcase
                end
                MODE_PROG: begin
                    mode_d = MODE_STATUS;
                    if (guarded) status_d = status_q | ERR_LOCK_PROG;
                    else         op.prog  = 1'b1;
                end
                MODE_ERASE: begin
                    if (wr_data == CMD_CONFIRM) begin
                        mode_d = MODE_STATUS;
                        if (guarded) status_d = status_q | ERR_LOCK_ERASE;
                        else         op.erase = 1'b1;
                    end
                end
                MODE_LOCK: begin
                    mode_d = MODE_STATUS;
                    case (wr_data)
                        SUB_MASTER: begin
                            if (hard_unlock) op.master_set = 1'b1;
                            else             status_d = status_q | ERR_LOCK_PROG;
                        end
                        SUB_BLK_LOCK: begin
                            if (master_guard) status_d = status_q | ERR_LOCK_PROG;
                            else              op.lock_set = 1'b1;
                        end
                        CMD_CONFIRM: begin
                            if (master_guard) status_d = status_q | ERR_LOCK_ERASE;
                            else              op.lock_clr = 1'b1;
                        end
                        SUB_READ_CFG: status_d = status_q;
                        default:      status_d = status_q | ERR_SEQUENCE;
                    endcase
                end
                MODE_CONF: mode_d = MODE_STATUS;
                default:   mode_d = MODE_ARRAY;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q   <= MODE_ARRAY;
            status_q <= STATUS_RESET;
        end else begin
            mode_q   <= mode_d;
            status_q <= status_d;
        end
    end

    assign mode   = mode_q;
    assign status = status_q;

endmodule

// File: rtl/fci_byte_array.sv
module fci_byte_array #(
    parameter int ADDR_W      = 6,
    parameter int BLOCK_BYTES = 16
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         prog,
    input  logic                         erase,
    input  logic [ADDR_W-1:0]            addr,
    input  logic [7:0]                   wr_data,
    output logic [(1<<ADDR_W)-1:0][7:0]  mem
);

    localparam int DEPTH = 1 << ADDR_W;
    localparam int BLK_W = $clog2(BLOCK_BYTES);

    logic [(1<<ADDR_W)-1:0][7:0] mem_q;

    for (genvar g = 0; g < DEPTH; g++) begin : g_byte
        localparam logic [ADDR_W-1:0] MY_ADDR = ADDR_W'(g);
        logic hit_byte;
        logic hit_block;
        assign hit_byte  = (addr == MY_ADDR);
        assign hit_block = (addr[ADDR_W-1:BLK_W] == MY_ADDR[ADDR_W-1:BLK_W]);

        always_ff @(posedge clk) begin
            if (rst) begin
                mem_q[g] <= 8'hFF;
            end else if (erase && hit_block) begin
                mem_q[g] <= 8'hFF;
            end else if (prog && hit_byte) begin
                mem_q[g] <= mem_q[g] & wr_data;
            end
        end
    end

    assign mem = mem_q;

endmodule

// File: rtl/fci_lock_regs.sv
module fci_lock_regs #(
    parameter int NUM_BLOCKS = 4,
    parameter int IDX_W      = 2
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  lock_set,
    input  logic                  lock_clr,
    input  logic                  master_set,
    input  logic [IDX_W-1:0]      blk_idx,
    output logic [NUM_BLOCKS-1:0] blk_lock,
    output logic                  master_lock
);

    logic [NUM_BLOCKS-1:0] lock_q;
    logic                  master_q;

    for (genvar b = 0; b < NUM_BLOCKS; b++) begin : g_lock
        always_ff @(posedge clk) begin
            if (rst) begin
                lock_q[b] <= 1'b0;
            end else if (blk_idx == IDX_W'(b)) begin
                if (lock_set)      lock_q[b] <= 1'b1;
                else if (lock_clr) lock_q[b] <= 1'b0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst)             master_q <= 1'b0;
        else if (master_set) master_q <= 1'b1;
    end

    assign blk_lock    = lock_q;
    assign master_lock = master_q;

endmodule

// File: rtl/fci_read_port.sv
module fci_read_port
    import fci_pkg::*;
#(
    parameter int ADDR_W      = 6,
    parameter int BLOCK_BYTES = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    input  fci_mode_e         mode,
    input  logic [7:0]        status,
    input  logic [7:0]        array_byte,
    input  logic              blk_lock,
    input  logic              master_lock,
    output logic [7:0]        rd_data
);

    localparam int BLK_W = $clog2(BLOCK_BYTES);

    logic [15:0] word;
    logic [7:0]  ident_val;
    logic [7:0]  query_val;
    logic [7:0]  sel_val;
    logic [7:0]  rd_q;

    assign word = 16'(addr) >> 1;

    always_comb begin
        if (word == 16'd0)                       ident_val = CODE_MAKER;
        else if (word == 16'd1)                  ident_val = CODE_DEVICE;
        else if (word == 16'd3)                  ident_val = {7'd0, master_lock};
        else if (addr[BLK_W-1:1] == (BLK_W-1)'(2)) ident_val = {7'd0, blk_lock};
        else                                     ident_val = 8'h00;
    end

    always_comb begin
        if (word == 16'd0)      query_val = CODE_MAKER;
        else if (word == 16'd1) query_val = CODE_DEVICE;
        else                    query_val = query_sig(word);
    end

    always_comb begin
        case (mode)
            MODE_IDENT:  sel_val = ident_val;
            MODE_QUERY:  sel_val = query_val;
            MODE_STATUS: sel_val = status;
            default:     sel_val = array_byte;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst)        rd_q <= 8'h00;
        else if (rd_en) rd_q <= sel_val;
    end

    assign rd_data = rd_q;

endmodule

// File: rtl/flash_cmd_ctrl.sv
module flash_cmd_ctrl
    import fci_pkg::*;
#(
    parameter int ADDR_W      = 6,
    parameter int BLOCK_BYTES = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] addr,
    input  logic [7:0]        wr_data,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic              hard_unlock,
    output logic [7:0]        rd_data
);

    localparam int DEPTH      = 1 << ADDR_W;
    localparam int BLK_W      = $clog2(BLOCK_BYTES);
    localparam int NUM_BLOCKS = DEPTH / BLOCK_BYTES;
    localparam int IDX_W      = ADDR_W - BLK_W;

    fci_mode_e                  mode_w;
    logic [7:0]                 status_w;
    fci_op_t                    op_w;
    logic [DEPTH-1:0][7:0]      mem_w;
    logic [NUM_BLOCKS-1:0]      lock_w;
    logic                       master_w;
    logic [IDX_W-1:0]           blk_idx;
    logic                       cur_locked;

    assign blk_idx    = addr[ADDR_W-1:BLK_W];
    assign cur_locked = lock_w[blk_idx];

    fci_cmd_fsm u_fsm (
        .clk         (clk),
        .rst         (rst),
        .wr_en       (wr_en),
        .wr_data     (wr_data),
        .blk_locked  (cur_locked),
        .master_lock (master_w),
        .hard_unlock (hard_unlock),
        .mode        (mode_w),
        .status      (status_w),
        .op          (op_w)
    );

    fci_byte_array #(
        .ADDR_W      (ADDR_W),
        .BLOCK_BYTES (BLOCK_BYTES)
    ) u_array (
        .clk     (clk),
        .rst     (rst),
        .prog    (op_w.prog),
        .erase   (op_w.erase),
        .addr    (addr),
        .wr_data (wr_data),
        .mem     (mem_w)
    );

    fci_lock_regs #(
        .NUM_BLOCKS (NUM_BLOCKS),
        .IDX_W      (IDX_W)
    ) u_locks (
        .clk         (clk),
        .rst         (rst),
        .lock_set    (op_w.lock_set),
        .lock_clr    (op_w.lock_clr),
        .master_set  (op_w.master_set),
        .blk_idx     (blk_idx),
        .blk_lock    (lock_w),
        .master_lock (master_w)
    );

    fci_read_port #(
        .ADDR_W      (ADDR_W),
        .BLOCK_BYTES (BLOCK_BYTES)
    ) u_rd (
        .clk         (clk),
        .rst         (rst),
        .rd_en       (rd_en),
        .addr        (addr),
        .mode        (mode_w),
        .status      (status_w),
        .array_byte  (mem_w[addr]),
        .blk_lock    (cur_locked),
        .master_lock (master_w),
        .rd_data     (rd_data)
    );

endmodule

// File: rtl/fci_checker.sv
module fci_checker
    import fci_pkg::*;
#(
    parameter int ADDR_W      = 6,
    parameter int BLOCK_BYTES = 16
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic [ADDR_W-1:0]           addr,
    input  logic [7:0]                  wr_data,
    input  logic                        wr_en,
    input  logic                        rd_en,
    input  logic                        hard_unlock,
    input  logic [7:0]                  rd_data,
    input  fci_mode_e                   mode,
    input  logic [7:0]                  status,
    input  logic [(1<<ADDR_W)-1:0][7:0] mem,
    input  logic [((1<<ADDR_W)/BLOCK_BYTES)-1:0] blk_lock
);

    localparam int BLK_W = $clog2(BLOCK_BYTES);

    logic clear_cmd;
    logic locked_here;

    assign clear_cmd   = wr_en && is_read_mode(mode) && (wr_data == CMD_CLR_STATUS);
    assign locked_here = blk_lock[addr[ADDR_W-1:BLK_W]] && !hard_unlock;

    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (rst)
        !clear_cmd |=> ((($past(status) & ~status) & ERR_FLAGS) == 8'h00)); // R3

    AST_PROG_CLEARS_ONLY: assert property (@(posedge clk) disable iff (rst)
        (wr_en && mode == MODE_PROG) |=> ((mem[$past(addr)] & ~$past(mem[addr])) == 8'h00)); // R4

    AST_PROG_TO_STATUS: assert property (@(posedge clk) disable iff (rst)
        (wr_en && mode == MODE_PROG) |=> (mode == MODE_STATUS)); // R4

    AST_LOCKED_PROG_KEEP: assert property (@(posedge clk) disable iff (rst)
        (wr_en && mode == MODE_PROG && locked_here)
        |=> (mem[$past(addr)] == $past(mem[addr])) && status[4] && status[1]); // R6

    AST_ERASE_WAITS: assert property (@(posedge clk) disable iff (rst)
        (wr_en && mode == MODE_ERASE && wr_data != CMD_CONFIRM) |=> (mode == MODE_ERASE)); // R5

    AST_LOCK_TO_STATUS: assert property (@(posedge clk) disable iff (rst)
        (wr_en && mode == MODE_LOCK) |=> (mode == MODE_STATUS)); // R9

    AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (rst)
        !rd_en |=> $stable(rd_data)); // R11

    AST_READY_KEPT: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> status[7]); // R1

endmodule

bind flash_cmd_ctrl fci_checker #(
    .ADDR_W      (ADDR_W),
    .BLOCK_BYTES (BLOCK_BYTES)
) u_chk (
    .clk         (clk),
    .rst         (rst),
    .addr        (addr),
    .wr_data     (wr_data),
    .wr_en       (wr_en),
    .rd_en       (rd_en),
    .hard_unlock (hard_unlock),
    .rd_data     (rd_data),
    .mode        (mode_w),
    .status      (status_w),
    .mem         (mem_w),
    .blk_lock    (lock_w)
);

// File: tb/flash_cmd_ctrl_tb.sv
module flash_cmd_ctrl_tb;

    localparam int AW    = 6;
    localparam int BLK   = 16;
    localparam int DEPTH = 1 << AW;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [AW-1:0] addr = '0;
    logic [7:0]    wr_data = 8'h00;
    logic          wr_en = 1'b0;
    logic          rd_en = 1'b0;
    logic          hard_unlock = 1'b0;
    logic [7:0]    rd_data;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    bit live = 0;

    // behavioural reference state
    int m_mem [DEPTH];
    int m_lock [DEPTH/BLK];
    int m_master;
    int m_mode;   // 0 array 1 ident 2 query 3 status 4 prog 5 erase 6 lock 7 conf
    int m_st;
    int exp_rd;

    flash_cmd_ctrl #(.ADDR_W(AW), .BLOCK_BYTES(BLK)) u_dut (
        .clk(clk), .rst(rst), .addr(addr), .wr_data(wr_data),
        .wr_en(wr_en), .rd_en(rd_en), .hard_unlock(hard_unlock), .rd_data(rd_data)
    );

    always #4 clk = ~clk;

    function automatic int m_read(int a);
        int w = a / 2;
        case (m_mode)
            1: begin
                if (w == 0) return 'h89;
                if (w == 1) return 'h15;
                if (w == 3) return m_master;
                if ((a % BLK) / 2 == 2) return m_lock[a / BLK];
                return 0;
            end
            2: begin
                if (w == 0) return 'h89;
                if (w == 1) return 'h15;
                if (w == 'h10) return 'h51;
                if (w == 'h11) return 'h52;
                if (w == 'h12) return 'h59;
                return 0;
            end
            3: return m_st;
            default: return m_mem[a];
        endcase
    endfunction

    task automatic m_write(int a, int d);
        bit guard = (m_lock[a / BLK] != 0) && !hard_unlock;
        bit mguard = (m_master != 0) && !hard_unlock;
        case (m_mode)
            0, 1, 2, 3: begin
                case (d)
                    'hFF: m_mode = 0;
                    'h90: m_mode = 1;
                    'h98: m_mode = 2;
                    'h70: m_mode = 3;
                    'h50: begin m_mode = 3; m_st = m_st & 'hC5; end
                    'h40, 'h10: m_mode = 4;
                    'h20: m_mode = 5;
                    'hB8: m_mode = 7;
                    'h60: m_mode = 6;
                    default: ;
                endcase
            end
            4: begin
                if (guard) m_st = m_st | 'h12;
                else m_mem[a] = m_mem[a] & d;
                m_mode = 3;
            end
            5: if (d == 'hD0) begin
                if (guard) m_st = m_st | 'h22;
                else for (int i = 0; i < BLK; i++) m_mem[(a / BLK) * BLK + i] = 'hFF;
                m_mode = 3;
            end
            6: begin
                case (d)
                    'hF1: if (hard_unlock) m_master = 1; else m_st = m_st | 'h12;
                    'h01: if (mguard) m_st = m_st | 'h12; else m_lock[a / BLK] = 1;
                    'hD0: if (mguard) m_st = m_st | 'h22; else m_lock[a / BLK] = 0;
                    'h03: ;
                    default: m_st = m_st | 'h30;
                endcase
                m_mode = 3;
            end
            default: m_mode = 3;
        endcase
    endtask

    always @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) m_mem[i] = 'hFF;
            for (int i = 0; i < DEPTH/BLK; i++) m_lock[i] = 0;
            m_master = 0; m_mode = 0; m_st = 'h80; exp_rd = 0;
        end else begin
            if (rd_en) exp_rd = m_read(int'(addr));
            if (wr_en) m_write(int'(addr), int'(wr_data));
        end
    end

    task automatic check(int act, int exp, string tag);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
        end
    endtask

    // per-cycle comparison against the reference model
    always @(negedge clk) begin
        if (live && !rst) check(int'(rd_data), exp_rd, "R11 model");
    end

    task automatic wr(int a, int d);
        @(negedge clk);
        addr = AW'(a); wr_data = 8'(d); wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(int a, int exp, string tag);
        @(negedge clk);
        addr = AW'(a); rd_en = 1'b1;
        @(negedge clk);
        rd_en = 1'b0;
        check(int'(rd_data), exp, tag);
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000) begin
            errors++;
            $display("FAIL watchdog actual=%0d expected=<20000", cycles);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        live = 1;
        check(int'(rd_data), 'h00, "R1 rd_data reset");
        rd(0, 'hFF, "R1 array reset");
        rd(DEPTH - 1, 'hFF, "R1 array reset top");
        wr(0, 'h70); rd(0, 'h80, "R1 status reset");

        wr(0, 'h90);
        rd(0, 'h89, "R7 maker");
        rd(3, 'h15, "R7 device");
        rd(4, 'h00, "R7 block0 unlocked");
        rd(6, 'h00, "R7 master clear");
        wr(0, 'h98);
        rd('h20, 'h51, "R8 Q");
        rd('h23, 'h52, "R8 R");
        rd('h25, 'h59, "R8 Y");
        rd(1, 'h89, "R8 maker");
        rd('h30, 'h00, "R8 other");
        wr(0, 'h70); wr(0, 'h98);
        rd('h22, 'h52, "R2 query from status");

        wr(0, 'hFF); rd(5, 'hFF, "R2 array select");
        wr(5, 'h40); wr(5, 'hA5); rd(5, 'h80, "R4 status after program");
        wr(0, 'hFF); rd(5, 'hA5, "R4 program");
        wr(5, 'h10); wr(5, 'h3C); wr(0, 'hFF); rd(5, 'h24, "R4 and only");
        wr(17, 'h40); wr(17, 'h00);

        wr(5, 'h20); wr(5, 'h00);
        rd(5, 'h24, "R5 erase still armed");
        wr(5, 'hD0); rd(5, 'h80, "R5 status after erase");
        wr(0, 'hFF);
        rd(5, 'hFF, "R5 block erased");
        rd(17, 'h00, "R5 other block kept");

        wr(16, 'h60); wr(16, 'h01); rd(0, 'h80, "R9 lock set status");
        wr(0, 'h90);
        rd(20, 'h01, "R9 block1 locked");
        rd(4, 'h00, "R7 block0 lock bit");
        wr(17, 'h40); wr(17, 'h0F); rd(17, 'h92, "R6 locked program");
        wr(17, 'h20); wr(17, 'hD0); rd(17, 'hB2, "R6 locked erase");
        wr(0, 'hFF); rd(17, 'h00, "R6 array unchanged");
        wr(0, 'h70); rd(0, 'hB2, "R3 errors sticky");
        wr(0, 'h50); rd(0, 'h80, "R3 clear status");

        hard_unlock = 1'b1;
        wr(17, 'h20); wr(17, 'hD0);
        wr(17, 'h40); wr(17, 'h5A);
        hard_unlock = 1'b0;
        wr(0, 'hFF); rd(17, 'h5A, "R6 hard unlock"); rd(16, 'hFF, "R6 hard unlock erase");

        wr(0, 'h60); wr(0, 'hF1); rd(0, 'h92, "R9 master refused");
        wr(0, 'h50);
        hard_unlock = 1'b1; wr(0, 'h60); wr(0, 'hF1); hard_unlock = 1'b0;
        wr(0, 'h90); rd(6, 'h01, "R7 master set");
        wr(16, 'h60); wr(16, 'hD0); rd(0, 'hA2, "R9 clear refused");
        wr(0, 'h90); rd(20, 'h01, "R9 lock kept");
        wr(0, 'h60); wr(0, 'h01); rd(0, 'hB2, "R9 set refused");
        wr(0, 'h50);
        wr(0, 'h60); wr(0, 'h77); rd(0, 'hB0, "R9 bad sub-command");
        wr(0, 'h50);
        wr(0, 'h60); wr(0, 'h03); rd(0, 'h80, "R9 read-config ignored");

        wr(0, 'hB0); wr(0, 'hD0); wr(0, 'h33);
        rd(0, 'h80, "R10 ignored bytes");
        wr(5, 'hB8); wr(5, 'h00); rd(5, 'h80, "R10 config consumed");
        wr(0, 'hFF); rd(5, 'hFF, "R10 array untouched");

        @(negedge clk); addr = AW'(17);
        repeat (2) @(negedge clk);
        check(int'(rd_data), 'hFF, "R11 hold without rd_en");

        repeat (2) @(negedge clk);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule